// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block turns the single-bit output of an infrared demodulator into a stream of run-length bytes. The input is sampled once every `SAMPLE_DIV` clocks. The polarity can be flipped first. Short excursions that do not outlast a programmable noise threshold are folded into the run in progress. Each confirmed run is reported as one byte: the run's level sits in the top bit and the run length minus one sits in the low seven bits. A run longer than 128 samples is reported as several bytes.

When the line rests at the idle level for a programmable multiple of 128 samples, the block gives up on the idle run and pulses a packet-end strobe. It then stays silent until the line goes active again. Three configuration words are plain input ports:
- a control word, which gates the block on;
- a receive word, which carries the polarity flip;
- a sample word, which carries the noise and idle thresholds.

The bytes leave through a single-cycle write strobe, ready for a receive FIFO.

Top module: `ir_rle_rx`

## Requirements
- R1: The input is sampled once per `SAMPLE_DIV` clocks. The first sample is taken on the `SAMPLE_DIV`-th rising edge after the block is enabled, and each later sample follows every `SAMPLE_DIV` edges after that.
- R2: Each emitted byte carries the run level in bit 7 (1 = active) and the run length minus one in bits 6:0, so one byte covers 1 to 128 samples. A byte is emitted when a level change is accepted.
- R3: When a run's accumulated length reaches 128 samples, a byte with length field 0x7F and the run's level is emitted at once. Counting continues with the remainder.
- R4: The noise threshold N is in `smp_cfg` bits 7:2. A change of level that lasts N samples or fewer is added to the current run. The change is accepted on its (N+1)-th consecutive sample, and the new run then already holds N+1 samples.
- R5: The idle threshold T is in `smp_cfg` bits 15:8. On the (T+1)×128-th sample of a run at level 0, `pkt_end` pulses for one cycle. The unreported part of that run is discarded and no byte is emitted for it.
- R6: After reset, after a packet end, or after being disabled, nothing is emitted until an active (level 1) sample arrives. The next byte therefore has bit 7 set.
- R7: Bit 2 of `rx_cfg` inverts the input before sampling.
- R8: The block is active only while `ctrl` bit 0 (global enable) and bit 1 (receive enable) are both set and bits 5:4 equal 2'b11. While inactive it emits nothing, and its run state and sample divider return to their initial values.
- R9: `byte_valid` and `pkt_end` are registered one cycle after the sampling edge. Each is a single-cycle strobe, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctrl | input | 8 | Control word: bit 0 global enable, bit 1 receive enable, bits 5:4 mode |
| rx_cfg | input | 8 | Receive word: bit 2 inverts the input |
| smp_cfg | input | 16 | Sample word: bits 7:2 noise threshold, bits 15:8 idle threshold |
| ir_in | input | 1 | Demodulated infrared input |
| byte_valid | output | 1 | Single-cycle write strobe for `byte_data` |
| byte_data | output | 8 | Run byte: level in bit 7, length minus one in bits 6:0 |
| pkt_end | output | 1 | Single-cycle packet-end strobe |

## Verification
The bench drives several runs whose lengths land exactly on and just past 128 samples. A design that splits runs at the wrong point emits a length off by one, or misses the 0x7F byte.

Glitches of exactly N and N+1 samples are sent. A wrong comparison in the noise filter either breaks a run in two or swallows a real edge, and a wrong hand-over loses the N+1 samples that belong to the new run.

Idle runs are made just long enough to reach the timeout, which lands on the same sample where a 0x7F split would fall. A design with the wrong priority emits an idle byte before `pkt_end`. Long idle stretches are also driven after a packet end, and a design that does not return to waiting leaks level-0 bytes there.

Inverted polarity and each missing enable bit are tried as well. A design that ignores these produces bytes where none should appear.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } rle_state_e;

  localparam logic [1:0] MODE_IR   = 2'b11;
  localparam int unsigned GEN_BIT  = 0;
  localparam int unsigned RXEN_BIT = 1;
  localparam int unsigned MODE_LSB = 4;
  localparam int unsigned INV_BIT  = 2;
  localparam int unsigned NTHR_LSB = 2;
  localparam int unsigned ITHR_LSB = 8;
endpackage

// File: rtl/ir_rle_rst_sync.sv
module ir_rle_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ir_rle_cfg.sv
module ir_rle_cfg
  import ir_rle_pkg::*;
#(
  parameter int unsigned NTHR_W = 6,
  parameter int unsigned ITHR_W = 8,
  parameter int unsigned LEN_W  = 7,
  localparam int unsigned SMP_W  = ITHR_LSB + ITHR_W,
  localparam int unsigned IDLE_W = ITHR_W + 1 + LEN_W
) (
  input  logic [7:0]        ctrl,
  input  logic [7:0]        rx_cfg,
  input  logic [SMP_W-1:0]  smp_cfg,
  output logic              enable,
  output logic              invert,
  output logic [NTHR_W-1:0] noise_thr,
  output logic [IDLE_W-1:0] idle_limit
);
  logic [ITHR_W-1:0] idle_thr;
  logic              unused_cfg_bits;

  assign enable     = ctrl[GEN_BIT] & ctrl[RXEN_BIT] &
                      (ctrl[MODE_LSB +: 2] == MODE_IR);
  assign invert     = rx_cfg[INV_BIT];
  assign noise_thr  = smp_cfg[NTHR_LSB +: NTHR_W];
  assign idle_thr   = smp_cfg[ITHR_LSB +: ITHR_W];
  // (T+1) * 2^LEN_W samples of idle level end a packet
  assign idle_limit = {1'b0, idle_thr, {LEN_W{1'b0}}} + {1'b1, {LEN_W{1'b0}}};

  assign unused_cfg_bits = ^{ctrl[7:6], ctrl[3:2], rx_cfg[7:3], rx_cfg[1:0], smp_cfg[1:0]};
endmodule

// File: rtl/ir_rle_tick.sv
module ir_rle_tick #(
  parameter int unsigned SAMPLE_DIV = 64,
  localparam int unsigned CNT_W = (SAMPLE_DIV > 2) ? $clog2(SAMPLE_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = enable && (cnt_q == CNT_W'(SAMPLE_DIV - 1));

  always_comb begin
    if (!enable || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ir_rle_core.sv
module ir_rle_core
  import ir_rle_pkg::*;
#(
  parameter int unsigned LEN_W  = 7,
  parameter int unsigned NTHR_W = 6,
  parameter int unsigned IDLE_W = 16,
  localparam int unsigned CNT_W = LEN_W + 1,
  localparam int unsigned DEV_W = NTHR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              smp_bit,
  input  logic [NTHR_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              byte_valid,
  output logic [LEN_W:0]    byte_data,
  output logic              pkt_end
);
  rle_state_e        state_q, state_d;
  logic              lvl_q, lvl_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic [DEV_W-1:0]  dev_q, dev_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              vld_d, pe_d;
  logic [LEN_W:0]    byte_d;

  logic [CNT_W-1:0]  len_sum;
  logic [DEV_W-1:0]  dev_inc;
  logic [IDLE_W-1:0] idle_inc;
  logic              change_ok;
  logic              idle_hit;

  assign len_sum   = len_q + {{(CNT_W-DEV_W){1'b0}}, dev_q} + 1'b1;
  assign dev_inc   = dev_q + 1'b1;
  assign idle_inc  = idle_q + 1'b1;
  assign change_ok = dev_inc > {1'b0, noise_thr};
  assign idle_hit  = !lvl_q && (idle_inc == idle_limit);

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    len_d   = len_q;
    dev_d   = dev_q;
    idle_d  = idle_q;
    vld_d   = 1'b0;
    pe_d    = 1'b0;
    byte_d  = '0;
    if (!enable) begin
      state_d = ST_WAIT;
      lvl_d   = 1'b0;
      len_d   = '0;
      dev_d   = '0;
      idle_d  = '0;
    end else if (tick) begin
      unique case (state_q)
        ST_WAIT: begin
          if (smp_bit) begin
            state_d = ST_RUN;
            lvl_d   = 1'b1;
            len_d   = CNT_W'(1);
            dev_d   = '0;
            idle_d  = '0;
          end
        end
        ST_RUN: begin
          if (idle_hit) begin
            // timeout wins over any split on this sample
            pe_d    = 1'b1;
            state_d = ST_WAIT;
            lvl_d   = 1'b0;
            len_d   = '0;
            dev_d   = '0;
            idle_d  = '0;
          end else if (smp_bit == lvl_q) begin
            dev_d  = '0;
            idle_d = lvl_q ? '0 : idle_inc;
            if (len_sum[LEN_W]) begin
              vld_d  = 1'b1;
              byte_d = {lvl_q, {LEN_W{1'b1}}};
              len_d  = {1'b0, len_sum[LEN_W-1:0]};
            end else begin
              len_d  = len_sum;
            end
          end else if (change_ok) begin
            if (len_q != '0) begin
              vld_d  = 1'b1;
              byte_d = {lvl_q, len_q[LEN_W-1:0] - 1'b1};
            end
            lvl_d  = smp_bit;
            len_d  = {{(CNT_W-DEV_W){1'b0}}, dev_inc};
            dev_d  = '0;
            idle_d = smp_bit ? '0 : {{(IDLE_W-DEV_W){1'b0}}, dev_inc};
          end else begin
            dev_d  = dev_inc;
            idle_d = lvl_q ? '0 : idle_inc;
          end
        end
        default: state_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_WAIT;
      lvl_q      <= 1'b0;
      len_q      <= '0;
      dev_q      <= '0;
      idle_q     <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      pkt_end    <= 1'b0;
    end else begin
      state_q    <= state_d;
      lvl_q      <= lvl_d;
      len_q      <= len_d;
      dev_q      <= dev_d;
      idle_q     <= idle_d;
      byte_valid <= vld_d;
      byte_data  <= byte_d;
      pkt_end    <= pe_d;
    end
  end
endmodule

// File: rtl/ir_rle_rx.sv
module ir_rle_rx
  import ir_rle_pkg::*;
#(
  parameter int unsigned SAMPLE_DIV = 64,
  parameter int unsigned LEN_W      = 7,
  parameter int unsigned NTHR_W     = 6,
  parameter int unsigned ITHR_W     = 8,
  localparam int unsigned SMP_W  = ITHR_LSB + ITHR_W,
  localparam int unsigned IDLE_W = ITHR_W + 1 + LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ctrl,
  input  logic [7:0]       rx_cfg,
  input  logic [SMP_W-1:0] smp_cfg,
  input  logic             ir_in,
  output logic             byte_valid,
  output logic [LEN_W:0]   byte_data,
  output logic             pkt_end
);
  logic              rst_sync_n;
  logic              enable;
  logic              invert;
  logic [NTHR_W-1:0] noise_thr;
  logic [IDLE_W-1:0] idle_limit;
  logic              tick;
  logic              smp_bit;

  ir_rle_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ir_rle_cfg #(.NTHR_W(NTHR_W), .ITHR_W(ITHR_W), .LEN_W(LEN_W)) u_cfg (
    .ctrl       (ctrl),
    .rx_cfg     (rx_cfg),
    .smp_cfg    (smp_cfg),
    .enable     (enable),
    .invert     (invert),
    .noise_thr  (noise_thr),
    .idle_limit (idle_limit)
  );

  ir_rle_tick #(.SAMPLE_DIV(SAMPLE_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .enable (enable),
    .tick   (tick)
  );

  assign smp_bit = ir_in ^ invert;

  ir_rle_core #(.LEN_W(LEN_W), .NTHR_W(NTHR_W), .IDLE_W(IDLE_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .enable     (enable),
    .tick       (tick),
    .smp_bit    (smp_bit),
    .noise_thr  (noise_thr),
    .idle_limit (idle_limit),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .pkt_end    (pkt_end)
  );
endmodule

// File: rtl/ir_rle_rx_chk.sv
module ir_rle_rx_chk #(
  parameter int unsigned LEN_W = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     ctrl,
  input logic           byte_valid,
  input logic [LEN_W:0] byte_data,
  input logic           pkt_end
);
  logic en_now;
  logic fresh_q;

  assign en_now = ctrl[0] & ctrl[1] & (ctrl[5:4] == 2'b11);

  // set when the next byte must start an active run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 fresh_q <= 1'b1;
    else if (pkt_end || !en_now) fresh_q <= 1'b1;
    else if (byte_valid)         fresh_q <= 1'b0;
  end

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && pkt_end));

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_pkt_end_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !pkt_end);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_now |=> (!byte_valid && !pkt_end));

  assert_first_byte_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && fresh_q) |-> byte_data[LEN_W]);
endmodule

bind ir_rle_rx ir_rle_rx_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl       (ctrl),
  .byte_valid (byte_valid),
  .byte_data  (byte_data),
  .pkt_end    (pkt_end)
);

// File: tb/ir_rle_rx_tb_top.sv
module ir_rle_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int PE_MARK    = 256;
  localparam int WD_LIMIT   = 190000;

  logic       clk;
  logic       rst_n;
  logic [7:0] ctrl;
  logic [7:0] rx_cfg;
  logic [15:0] smp_cfg;
  logic       ir_in;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       pkt_end;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit collect = 1'b0;
  bit raw_q[$];
  int exp_q[$];
  int got_q[$];

  ir_rle_rx #(.SAMPLE_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .rx_cfg(rx_cfg), .smp_cfg(smp_cfg),
    .ir_in(ir_in), .byte_valid(byte_valid), .byte_data(byte_data), .pkt_end(pkt_end)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (collect) begin
      if (byte_valid) got_q.push_back(int'(byte_data));
      if (pkt_end)    got_q.push_back(PE_MARK);
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WD_LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // expected stream from R2..R8; 256 marks a packet end
  task automatic model(input bit inv, input int nthr, input int ithr, input bit en);
    int st = 0;
    int lvl = 0;
    int n = 0;
    int d = 0;
    int idle = 0;
    int lim;
    bit s;
    exp_q.delete();
    lim = (ithr + 1) * 128;
    if (!en) return;
    foreach (raw_q[i]) begin
      s = raw_q[i] ^ inv;
      if (st == 0) begin
        if (s) begin st = 1; lvl = 1; n = 1; d = 0; idle = 0; end
      end else if (lvl == 0 && idle + 1 == lim) begin
        exp_q.push_back(PE_MARK); st = 0; n = 0; d = 0; idle = 0;
      end else if (int'(s) == lvl) begin
        n = n + d + 1; d = 0;
        if (n >= 128) begin exp_q.push_back(lvl * 128 + 127); n = n - 128; end
        if (lvl == 0) idle = idle + 1;
      end else begin
        d = d + 1;
        if (d > nthr) begin
          if (n > 0) exp_q.push_back(lvl * 128 + n - 1);
          lvl = int'(s); n = d; d = 0; idle = s ? 0 : n;
        end else if (lvl == 0) idle = idle + 1;
      end
    end
  endtask

  task automatic add_run(input bit v, input int len);
    for (int k = 0; k < len; k++) raw_q.push_back(v);
  endtask

  task automatic scenario(input string req, input logic [7:0] c, input bit inv,
                          input int nthr, input int ithr);
    bit en;
    en = c[0] & c[1] & (c[5:4] == 2'b11);
    model(inv, nthr, ithr, en);
    @(negedge clk);
    ctrl = 8'h00;
    repeat (3) @(negedge clk);
    got_q.delete();
    collect = 1'b1;
    rx_cfg  = inv ? 8'h04 : 8'h00;
    smp_cfg = {8'(ithr), 6'(nthr), 2'b00};
    ctrl    = c;
    foreach (raw_q[i]) begin
      ir_in = raw_q[i];
      repeat (DIV) @(posedge clk);
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    collect = 1'b0;
    check(got_q.size() == exp_q.size(), {req, " count"}, got_q.size(), exp_q.size());
    foreach (exp_q[i]) begin
      if (i < got_q.size()) check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    end
    raw_q.delete();
  endtask

  initial begin
    int nthr;
    int ithr;
    bit inv;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; ctrl = 8'h00; rx_cfg = 8'h00; smp_cfg = 16'h0000; ir_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6 reset state: no strobes
    check(byte_valid == 1'b0, "R6 reset byte_valid", byte_valid, 0);
    check(pkt_end == 1'b0, "R6 reset pkt_end", pkt_end, 0);

    // R1,R2: short runs, no filtering, timeout after 128 idle samples (0x84 0x02 0x80 PE)
    add_run(1, 5); add_run(0, 3); add_run(1, 1); add_run(0, 200);
    scenario("R1,R2 basic", 8'h33, 0, 0, 0);

    // R3: long active run split into 0x7F bytes, long idle split before timeout
    add_run(1, 300); add_run(0, 300);
    scenario("R3 split", 8'h33, 0, 0, 1);
    add_run(1, 128); add_run(0, 129); add_run(1, 127); add_run(0, 260);
    scenario("R3 boundary", 8'h33, 0, 0, 1);

    // R4: glitches of exactly N absorbed, N+1 accepted
    add_run(1, 10); add_run(0, 2); add_run(1, 10); add_run(0, 3); add_run(1, 5); add_run(0, 200);
    scenario("R4 noise", 8'h33, 0, 2, 0);

    // R5: timeout on the sample where a split would fall; R6: idle after end is silent
    add_run(1, 7); add_run(0, 400); add_run(1, 3); add_run(0, 130);
    scenario("R5,R6 timeout", 8'h33, 0, 0, 0);

    // R7: inverted input
    add_run(0, 9); add_run(1, 4); add_run(0, 2); add_run(1, 200);
    scenario("R7 invert", 8'h33, 1, 0, 0);

    // R8: wrong mode, missing global enable, missing receive enable
    add_run(1, 20); add_run(0, 5); add_run(1, 20);
    scenario("R8 mode", 8'h13, 0, 0, 0);
    add_run(1, 20); add_run(0, 5);
    scenario("R8 gen", 8'h32, 0, 0, 0);
    add_run(1, 20); add_run(0, 5);
    scenario("R8 rxen", 8'h31, 0, 0, 0);

    // random mix for R2..R7
    for (int t = 0; t < 12; t++) begin
      nthr = int'($urandom_range(0, 4));
      ithr = int'($urandom_range(0, 2));
      inv  = 1'($urandom_range(0, 1));
      for (int r = 0; r < 8; r++) begin
        add_run(~inv ^ 1'(r % 2), int'($urandom_range(1, 200)));
      end
      add_run(inv, (ithr + 1) * 128 + 10);
      scenario("R2,R3,R4,R5,R7 random", 8'h33, inv, nthr, ithr);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule